// File: doc/BRIEF.md
# Multi-Channel Shared-Clock ADC Reader

This block is a host controller for up to six two-wire serial load-cell converters that share a single clock line, each with its own data return line. One clock burst reads every converter at once. Each data line is sampled on the same internal edge, and one 24-bit word per channel is assembled most-significant bit first. The extra pulses after the data bits set the gain and input for the next conversion of every device.

A converter pulls its data line low when a result is ready. If that result is left unread, the converter raises the line again in periodic reminder pulses. A burst that overlaps one of those pulses corrupts the reading. The reader therefore records the age of each channel's most recent falling edge. It starts a burst only when every enabled channel has an edge younger than a configurable age limit, and only when a minimum launch spacing has passed. Edges that occur during a burst are discarded. The clock period, pulse count, age limit, launch spacing and stall timeout are all run-time configuration inputs.

Top module: `multi_adc_reader`

## Requirements
- R1: After reset, `adc_sck_o`, `valid_o`, `stall_o`, `missed_o` and every bit of `word_o` are low.
- R2: Each data bit is sampled on the last cycle of a clock high phase, through a two-flop synchronizer. Bit k of a burst (counted from 0) lands in word bit 23-k, so the first bit is the MSB. `valid_o` is high for exactly one cycle, the cycle after the final low phase ends, and `word_o` and `missed_o` update in that same cycle.
- R3: A burst contains 24 + E clock pulses, where E is `cfg_extra_i` (1, 2 or 3). A value of 0 is treated as 1. A new burst never starts while one is running.
- R4: Every clock high phase and every low phase lasts exactly `cfg_half_i` cycles. `cfg_half_i` must lie between 4 and HIGH_MAX, and the clock is never high for more than HIGH_MAX consecutive cycles.
- R5: Falling edges on the data lines are ignored while a burst is running and are not remembered after it. A burst that leaves every line high starts no further burst.
- R6: A channel becomes ready once its synchronized data line falls. It stays ready for exactly `cfg_age_limit_i` cycles and then drops out until its next falling edge.
- R7: A burst starts only in a cycle where every enabled channel is ready and at least one channel is enabled. Otherwise the reader waits.
- R8: Two successive burst starts are at least `cfg_min_period_i` cycles apart. When all channels are already ready, the gap is exactly that value.
- R9: A channel whose `ch_enable_i` bit is 0 is left out of the ready check. Its field in `word_o` reads 0 and its `missed_o` bit reads 0.
- R10: `missed_o[i]` is 1 for an enabled channel whose synchronized data line was high in the cycle the burst started.
- R11: While no burst starts, `stall_o` pulses for one cycle every `cfg_stall_limit_i` cycles (the limit must be at least 2). The reader keeps waiting and starts normally once all channels become ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable_i | input | NCH | Channels taking part in the ready check |
| cfg_extra_i | input | 2 | Pulses after the data bits (0 is treated as 1) |
| cfg_half_i | input | HALF_W | Length of each clock phase, in cycles |
| cfg_age_limit_i | input | TMR_W | Cycles a falling edge keeps a channel ready |
| cfg_min_period_i | input | TMR_W | Minimum cycles between burst starts |
| cfg_stall_limit_i | input | TMR_W | Waiting cycles between stall pulses |
| adc_dout_i | input | NCH | Per-channel serial data lines |
| adc_sck_o | output | 1 | Shared converter clock |
| valid_o | output | 1 | One-cycle strobe when a new set of words is available |
| word_o | output | NCH*DATA_W | Channel words; channel i occupies bits i*DATA_W upward |
| missed_o | output | NCH | Channels whose line was high when the burst started |
| stall_o | output | 1 | One-cycle pulse when no valid window appears in time |

## Verification
The assertions check on every cycle that:
- the clock high time stays bounded;
- each burst starts only when all enabled channels were ready and the launch spacing had passed;
- no burst restarts over a running one;
- readiness never rises while detection is muted;
- the valid and stall strobes last one cycle, and disabled channels report zero words.

Other properties can only be shown by the bench's scenarios:
- bit ordering within a word;
- the exact pulse count for each extra setting;
- expiry of a stale edge;
- that edges made by the data bits themselves are forgotten;
- the missed flag for a line raised mid-window;
- the exact stall period.

// File: rtl/mar_pkg.sv
package mar_pkg;

   typedef enum logic [1:0] {
      SCK_IDLE = 2'd0,
      SCK_HIGH = 2'd1,
      SCK_LOW  = 2'd2
   } sck_state_e;

   // Extra-pulse setting: zero is promoted to one
   function automatic logic [1:0] extra_eff(input logic [1:0] raw);
      return (raw == 2'd0) ? 2'd1 : raw;
   endfunction

endpackage

// File: rtl/mar_chan.sv
module mar_chan #(
   parameter int TMR_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din_i,
   input  logic             mute_i,
   input  logic [TMR_W-1:0] age_limit_i,
   output logic             level_o,
   output logic             ready_o
);

   logic             sync1_q, sync2_q, hist_q;
   logic             fall;
   logic [TMR_W-1:0] age_q;

   // Two-flop synchronizer plus one history flop for edge detection.
   // The history flop follows the line during mute, so no edge survives a burst.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync1_q <= 1'b1;
         sync2_q <= 1'b1;
         hist_q  <= 1'b1;
      end else begin
         sync1_q <= din_i;
         sync2_q <= sync1_q;
         hist_q  <= sync2_q;
      end
   end

   assign fall    = hist_q & ~sync2_q & ~mute_i;
   assign level_o = sync2_q;

   // Age window: ready holds for age_limit_i cycles after the edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_o <= 1'b0;
         age_q   <= '0;
      end else if (mute_i) begin
         ready_o <= 1'b0;
         age_q   <= '0;
      end else if (fall) begin
         ready_o <= 1'b1;
         age_q   <= '0;
      end else if (ready_o) begin
         if ((age_q + TMR_W'(1)) >= age_limit_i) ready_o <= 1'b0;
         else                                   age_q   <= age_q + TMR_W'(1);
      end
   end

   assert_mute_blocks_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> $past(!mute_i));

endmodule

// File: rtl/mar_shift.sv
module mar_shift #(
   parameter int DATA_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              shift_i,
   input  logic              bit_i,
   output logic [DATA_W-1:0] word_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_o <= '0;
      else if (clr_i)   word_o <= '0;
      else if (shift_i) word_o <= {word_o[DATA_W-2:0], bit_i};
   end

endmodule

// File: rtl/mar_sck.sv
module mar_sck
   import mar_pkg::*;
#(
   parameter int DATA_W   = 24,
   parameter int HALF_W   = 14,
   parameter int PCNT_W   = 5,
   parameter int HIGH_MAX = 9000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [HALF_W-1:0] half_i,
   input  logic [PCNT_W-1:0] npulse_i,
   output logic              sck_o,
   output logic              busy_o,
   output logic              sample_o,
   output logic              done_o
);

   sck_state_e        st_q;
   logic [HALF_W-1:0] cnt_q, half_q;
   logic [PCNT_W-1:0] pulse_q, npulse_q;
   logic              phase_end;

   assign phase_end = (cnt_q == half_q - HALF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SCK_IDLE;
         cnt_q    <= '0;
         half_q   <= '0;
         pulse_q  <= '0;
         npulse_q <= '0;
      end else begin
         unique case (st_q)
            SCK_IDLE: if (start_i) begin
               st_q     <= SCK_HIGH;
               cnt_q    <= '0;
               pulse_q  <= '0;
               half_q   <= half_i;
               npulse_q <= npulse_i;
            end
            SCK_HIGH: begin
               if (phase_end) begin
                  st_q  <= SCK_LOW;
                  cnt_q <= '0;
               end else cnt_q <= cnt_q + HALF_W'(1);
            end
            SCK_LOW: begin
               if (phase_end) begin
                  cnt_q <= '0;
                  if (pulse_q == npulse_q - PCNT_W'(1)) st_q <= SCK_IDLE;
                  else begin
                     st_q    <= SCK_HIGH;
                     pulse_q <= pulse_q + PCNT_W'(1);
                  end
               end else cnt_q <= cnt_q + HALF_W'(1);
            end
            default: st_q <= SCK_IDLE;
         endcase
      end
   end

   assign sck_o    = (st_q == SCK_HIGH);
   assign busy_o   = (st_q != SCK_IDLE);
   assign sample_o = sck_o && phase_end && (pulse_q < PCNT_W'(DATA_W));
   assign done_o   = (st_q == SCK_LOW) && phase_end && (pulse_q == npulse_q - PCNT_W'(1));

   // Checker: run length of the high level
   logic [HALF_W:0] hi_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_run_q <= '0;
      else if (sck_o) hi_run_q <= hi_run_q + (HALF_W+1)'(1);
      else            hi_run_q <= '0;
   end

   assert_high_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hi_run_q <= (HALF_W+1)'(HIGH_MAX));
   assert_half_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |-> (half_i >= HALF_W'(4) && half_i <= HALF_W'(HIGH_MAX)));
   assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

endmodule

// File: rtl/multi_adc_reader.sv
module multi_adc_reader
   import mar_pkg::*;
#(
   parameter int NCH      = 6,
   parameter int DATA_W   = 24,
   parameter int TMR_W    = 20,
   parameter int HALF_W   = 14,
   parameter int HIGH_MAX = 9000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        ch_enable_i,
   input  logic [1:0]            cfg_extra_i,
   input  logic [HALF_W-1:0]     cfg_half_i,
   input  logic [TMR_W-1:0]      cfg_age_limit_i,
   input  logic [TMR_W-1:0]      cfg_min_period_i,
   input  logic [TMR_W-1:0]      cfg_stall_limit_i,
   input  logic [NCH-1:0]        adc_dout_i,
   output logic                  adc_sck_o,
   output logic                  valid_o,
   output logic [NCH*DATA_W-1:0] word_o,
   output logic [NCH-1:0]        missed_o,
   output logic                  stall_o
);

   localparam int PCNT_W = $clog2(DATA_W + 4);

   if (NCH < 1 || NCH > 6) begin : g_bad_nch
      $error("multi_adc_reader: NCH must be 1..6");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("multi_adc_reader: DATA_W too small");
   end
   if (HIGH_MAX < 4 || HIGH_MAX >= (1 << HALF_W)) begin : g_bad_high
      $error("multi_adc_reader: HIGH_MAX must fit HALF_W and be at least 4");
   end
   if (TMR_W < 4) begin : g_bad_tmr
      $error("multi_adc_reader: TMR_W too small");
   end

   logic [NCH-1:0]    rdy_vec, line_lvl, miss_q;
   logic              gen_busy, bit_stb, gen_done, launch, all_ready, gap_ok;
   logic [TMR_W-1:0]  gap_q, stall_cnt_q;
   logic [PCNT_W-1:0] npulse;

   assign npulse    = PCNT_W'(DATA_W) + PCNT_W'(extra_eff(cfg_extra_i));
   assign all_ready = (&(rdy_vec | ~ch_enable_i)) && (|ch_enable_i);
   assign gap_ok    = (gap_q >= cfg_min_period_i);
   assign launch    = !gen_busy && all_ready && gap_ok;

   mar_sck #(
      .DATA_W(DATA_W), .HALF_W(HALF_W), .PCNT_W(PCNT_W), .HIGH_MAX(HIGH_MAX)
   ) u_sck (
      .clk(clk), .rst_n(rst_n), .start_i(launch), .half_i(cfg_half_i),
      .npulse_i(npulse), .sck_o(adc_sck_o), .busy_o(gen_busy),
      .sample_o(bit_stb), .done_o(gen_done)
   );

   // Cycles since the last launch, saturating; all ones after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            gap_q <= '1;
      else if (launch)       gap_q <= TMR_W'(1);
      else if (gap_q != '1)  gap_q <= gap_q + TMR_W'(1);
   end

   // Stall timer: runs while waiting for a window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall_cnt_q <= '0;
         stall_o     <= 1'b0;
      end else if (gen_busy || launch) begin
         stall_cnt_q <= '0;
         stall_o     <= 1'b0;
      end else if ((stall_cnt_q + TMR_W'(1)) >= cfg_stall_limit_i) begin
         stall_cnt_q <= '0;
         stall_o     <= 1'b1;
      end else begin
         stall_cnt_q <= stall_cnt_q + TMR_W'(1);
         stall_o     <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_q   <= '0;
         missed_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         if (launch)   miss_q   <= ch_enable_i & line_lvl;
         if (gen_done) missed_o <= miss_q;
         valid_o <= gen_done;
      end
   end

   for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      logic [DATA_W-1:0] sh_word, word_q;

      mar_chan #(.TMR_W(TMR_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .din_i(adc_dout_i[gi]), .mute_i(gen_busy),
         .age_limit_i(cfg_age_limit_i), .level_o(line_lvl[gi]), .ready_o(rdy_vec[gi])
      );

      mar_shift #(.DATA_W(DATA_W)) u_shift (
         .clk(clk), .rst_n(rst_n), .clr_i(launch), .shift_i(bit_stb),
         .bit_i(line_lvl[gi]), .word_o(sh_word)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        word_q <= '0;
         else if (gen_done) word_q <= ch_enable_i[gi] ? sh_word : '0;
      end

      assign word_o[gi*DATA_W +: DATA_W] = word_q;

      assert_disabled_word_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         valid_o |-> (word_q == '0 || $past(ch_enable_i[gi])));
   end

   assert_valid_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);
   assert_launch_all_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_busy) |-> $past((&(rdy_vec | ~ch_enable_i)) && (|ch_enable_i)));
   assert_launch_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gen_busy) |-> $past(gap_q >= cfg_min_period_i));
   assert_stall_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> !stall_o);

endmodule

// File: tb/tb_multi_adc_reader.sv
`timescale 1ns/1ps
module tb_multi_adc_reader;

   localparam int NCH = 6;
   localparam int DW  = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    ch_enable = 6'b001111;
   logic [1:0]        cfg_extra = 2'd1;
   logic [13:0]       cfg_half = 14'd4;
   logic [19:0]       cfg_age = 20'd400;
   logic [19:0]       cfg_minp = 20'd600;
   logic [19:0]       cfg_stall = 20'd200;
   logic [NCH-1:0]    din = '1;
   logic              adc_sck_o, valid_o, stall_o;
   logic [NCH*DW-1:0] word_o;
   logic [NCH-1:0]    missed_o;

   logic [DW-1:0] vals [NCH];
   longint cyc = 0;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   longint last_launch = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   multi_adc_reader dut (
      .clk(clk), .rst_n(rst_n), .ch_enable_i(ch_enable), .cfg_extra_i(cfg_extra),
      .cfg_half_i(cfg_half), .cfg_age_limit_i(cfg_age), .cfg_min_period_i(cfg_minp),
      .cfg_stall_limit_i(cfg_stall), .adc_dout_i(din), .adc_sck_o(adc_sck_o),
      .valid_o(valid_o), .word_o(word_o), .missed_o(missed_o), .stall_o(stall_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic pause(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic fall(input logic [NCH-1:0] m);
      din = din | m;
      pause(3);
      din = din & ~m;
   endtask

   task automatic quiet(input int n, input string req, input string what);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (adc_sck_o) seen++;
      end
      chk(seen == 0, req, what, seen, 0);
   endtask

   // Converter model: waits for a burst, drives one bit per rising clock edge,
   // releases the lines high after the data bits, returns once valid_o is seen
   task automatic serve(output int pulses, output int hi_len, output longint t_wait,
                        output longint t_launch);
      bit prev = 0;
      int guard = 0;
      longint t0 = cyc;
      pulses = 0; hi_len = 0; t_launch = 0;
      while (valid_o !== 1'b1 && guard < 5000) begin
         @(negedge clk);
         guard++;
         if (adc_sck_o && !prev) begin
            if (pulses == 0) t_launch = cyc;
            for (int i = 0; i < NCH; i++)
               din[i] = (pulses < DW) ? vals[i][DW-1-pulses] : 1'b1;
            pulses++;
         end
         if (adc_sck_o && pulses == 1) hi_len++;
         prev = adc_sck_o;
      end
      t_wait = t_launch - t0;
      chk(valid_o === 1'b1, "R2", "valid seen after burst", valid_o, 1);
      @(negedge clk);
      chk(valid_o == 1'b0, "R2", "valid lasts one cycle", valid_o, 0);
   endtask

   task automatic check_words(input string tag);
      for (int i = 0; i < NCH; i++) begin
         logic [DW-1:0] exp = ch_enable[i] ? vals[i] : '0;
         chk(word_o[i*DW +: DW] == exp, ch_enable[i] ? "R2" : "R9",
             $sformatf("%s word ch%0d", tag, i), word_o[i*DW +: DW], exp);
      end
   endtask

   task automatic set_vals(input int seed);
      for (int i = 0; i < NCH; i++)
         vals[i] = 24'hA5C3_96 ^ (24'h13579B * (seed + i + 1)) ^ {i[7:0], 16'h0F0F};
   endtask

   task automatic t_reset;
      chk(adc_sck_o == 0, "R1", "clock after reset", adc_sck_o, 0);
      chk(valid_o == 0 && stall_o == 0, "R1", "strobes after reset", {valid_o, stall_o}, 0);
      chk(word_o == '0 && missed_o == '0, "R1", "words and missed after reset", missed_o, 0);
   endtask

   task automatic t_basic;
      int p, h; longint w, tl;
      set_vals(1);
      fall(ch_enable);
      serve(p, h, w, tl);
      last_launch = tl;
      chk(w < 30, "R7", "launch once all ready", w, 10);
      chk(p == 25, "R3", "pulses with extra=1", p, 25);
      chk(h == 4, "R4", "high phase length", h, 4);
      check_words("basic");
      chk(missed_o == '0, "R10", "nothing missed", missed_o, 0);
   endtask

   task automatic t_mute;
      quiet(800, "R5", "edges from data bits forgotten");
   endtask

   task automatic t_wait_all;
      int p, h; longint w, tl;
      set_vals(2);
      fall(6'b000001);
      quiet(300, "R7", "one channel ready only");
      fall(6'b001110);
      serve(p, h, w, tl);
      chk(w < 30, "R7", "launch after last channel ready", w, 10);
      check_words("waitall");
   endtask

   task automatic t_expiry;
      int p, h; longint w, tl;
      set_vals(3);
      pause(700);
      fall(6'b000001);
      pause(450);
      fall(6'b001110);
      quiet(300, "R6", "stale edge expired");
      fall(6'b000001);
      serve(p, h, w, tl);
      chk(w < 30, "R6", "fresh edge restores ready", w, 10);
      check_words("expiry");
      last_launch = tl;
   endtask

   task automatic t_rate;
      int p, h; longint w, tl;
      set_vals(4);
      fall(ch_enable);
      serve(p, h, w, tl);
      last_launch = tl;
      set_vals(5);
      fall(ch_enable);
      serve(p, h, w, tl);
      chk(tl - last_launch == 600, "R8", "launch spacing", tl - last_launch, 600);
      check_words("rate");
   endtask

   task automatic t_variant(input logic [1:0] ex, input int half, input int exp_p, input int seed);
      int p, h; longint w, tl;
      cfg_extra = ex;
      cfg_half = 14'(half);
      set_vals(seed);
      pause(700);
      fall(ch_enable);
      serve(p, h, w, tl);
      chk(p == exp_p, "R3", $sformatf("pulses with extra=%0d", ex), p, exp_p);
      chk(h == half, "R4", "high phase length", h, half);
      check_words("variant");
   endtask

   task automatic t_mask;
      int p, h; longint w, tl;
      ch_enable = 6'b000101;
      set_vals(9);
      pause(700);
      fall(6'b000101);
      serve(p, h, w, tl);
      chk(w < 30, "R9", "disabled channels not awaited", w, 10);
      check_words("mask");
      chk(missed_o == '0, "R9", "disabled missed low", missed_o, 0);
      ch_enable = 6'b001111;
   endtask

   task automatic t_missed;
      int p, h; longint w, tl;
      set_vals(10);
      pause(700);
      fall(6'b000111);
      pause(3);
      din[2] = 1'b1;
      pause(10);
      fall(6'b001000);
      serve(p, h, w, tl);
      chk(missed_o == 6'b000100, "R10", "raised line flagged", missed_o, 6'b000100);
      check_words("missed");
   endtask

   task automatic t_stall;
      int rises = 0, highs = 0, sck_seen = 0;
      int p, h; longint w, tl;
      bit prev = stall_o;
      for (int i = 0; i < 1000; i++) begin
         @(negedge clk);
         if (stall_o) highs++;
         if (stall_o && !prev) rises++;
         if (adc_sck_o) sck_seen++;
         prev = stall_o;
      end
      chk(rises == 5, "R11", "stall pulses per 1000 cycles", rises, 5);
      chk(highs == rises, "R11", "stall pulse width", highs, rises);
      chk(sck_seen == 0, "R11", "still waiting", sck_seen, 0);
      set_vals(11);
      fall(ch_enable);
      serve(p, h, w, tl);
      chk(w < 30, "R11", "launch after stall", w, 10);
      check_words("stall");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      pause(5);
      t_reset();
      rst_n = 1'b1;
      pause(5);
      t_reset();
      t_basic();
      t_mute();
      t_wait_all();
      t_expiry();
      t_rate();
      t_variant(2'd3, 6, 27, 6);
      t_variant(2'd2, 5, 26, 7);
      t_variant(2'd0, 4, 25, 8);
      t_mask();
      t_missed();
      t_stall();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule